// File: doc/BRIEF.md
# Programming Status Readback Path

This block sits in the read path of a byte-wide nonvolatile memory and tells a polling host when an internal programming cycle has finished. While the busy flag is high, a read does not return array contents. It returns a status word built from the byte most recently loaded for programming:

- the top bit is the inverse of that byte's top bit;
- the next bit flips on every read;
- the six low bits pass through unchanged.

Once busy falls, reads return the array word again. The host can therefore detect completion in two ways: the top bit matches what was written, or the flipping bit stops flipping.

Each read is requested with a one-cycle strobe, and the result is held on the output register until the next strobe. The flipping bit restarts at 0 whenever a new programming cycle begins.

Top module: `pstat_readback`

## Requirements
- R1: After reset the read data output is 0x00.
- R2: A read taken while busy is high returns, in bit 7, the complement of bit 7 of the last loaded byte.
- R3: A read taken while busy is high returns, in bits 5 to 0, bits 5 to 0 of the last loaded byte.
- R4: Successive reads while busy is high return bit 6 as 0, 1, 0, 1, and so on.
- R5: A read taken while busy is low returns the full array word present on the array input.
- R6: Without a read strobe, the output holds its value and the bit-6 sequence does not advance, whatever the other inputs do.
- R7: Every rise of busy restarts the bit-6 sequence at 0, whatever value the previous programming cycle ended on.
- R8: A read strobed in the same cycle that busy rises returns bit 6 as 0, and the next busy read returns 1.
- R9: After busy falls, a read returns bit 7 with its true stored value.
- R10: The result of a strobed read appears on the output one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One-cycle read request |
| busy | input | 1 | High while an internal programming cycle runs |
| last_byte | input | 8 | Byte most recently loaded for programming |
| array_data | input | 8 | Array word at the current read address |
| rd_data | output | 8 | Registered read result |

## Verification
Two events can fall in the same cycle: the restart of the flipping bit when busy rises, and the advance of that bit on a read. The bench provokes this by raising busy and strobing a read on the same edge, after a previous cycle that ended with the bit at 1. It then expects 0 from that read and 1 from the next busy read. Restart and advance are also exercised apart from each other, with idle cycles between them, so that each one is judged on its own.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
  typedef enum logic {
    RD_ARRAY  = 1'b0,
    RD_STATUS = 1'b1
  } rd_src_e;
endpackage

// File: rtl/pstat_cycle_track.sv
// Tracks the start of each programming cycle and the per-read flip bit.
module pstat_cycle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic rd_stb,
  output logic busy_start,
  output logic status_rd,
  output logic tog_cur,
  output logic tog_q
);
  logic busy_q;
  logic tog_d;

  assign busy_start = busy & ~busy_q;
  // The restart value wins over the stored bit in the first busy cycle.
  assign tog_cur    = busy_start ? 1'b0 : tog_q;
  assign status_rd  = rd_stb & busy;
  assign tog_d      = status_rd ? ~tog_cur : tog_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      busy_q <= busy;
      tog_q  <= tog_d;
    end
  end
endmodule

// File: rtl/pstat_word_build.sv
// Builds either the status word or the array word.
module pstat_word_build
  import pstat_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  rd_src_e           src,
  input  logic [DATA_W-1:0] last_byte,
  input  logic [DATA_W-1:0] array_data,
  input  logic              tog,
  output logic [DATA_W-1:0] word
);
  function automatic logic [DATA_W-1:0] status_word(
    input logic [DATA_W-1:0] lb,
    input logic              t
  );
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) begin
      w[i] = lb[i];
    end
    w[POLL_BIT]   = ~lb[POLL_BIT];
    w[TOGGLE_BIT] = t;
    return w;
  endfunction

  always_comb begin
    if (src == RD_STATUS) word = status_word(last_byte, tog);
    else                  word = array_data;
  end
endmodule

// File: rtl/pstat_rd_reg.sv
module pstat_rd_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/pstat_readback.sv
module pstat_readback
  import pstat_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = DATA_W - 1,
  parameter int TOGGLE_BIT = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_byte,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);
  logic              busy_start;
  logic              status_rd;
  logic              tog_cur;
  logic              tog_q;
  rd_src_e           src;
  logic [DATA_W-1:0] word;

  assign src = busy ? RD_STATUS : RD_ARRAY;

  pstat_cycle_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .rd_stb     (rd_stb),
    .busy_start (busy_start),
    .status_rd  (status_rd),
    .tog_cur    (tog_cur),
    .tog_q      (tog_q)
  );

  pstat_word_build #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
  ) u_build (
    .src        (src),
    .last_byte  (last_byte),
    .array_data (array_data),
    .tog        (tog_cur),
    .word       (word)
  );

  pstat_rd_reg #(.DATA_W(DATA_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_stb),
    .d     (word),
    .q     (rd_data)
  );
endmodule

// File: rtl/pstat_readback_chk.sv
module pstat_readback_chk #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              busy,
  input logic [DATA_W-1:0] last_byte,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy_start,
  input logic              status_rd,
  input logic              tog_cur,
  input logic              tog_q
);
  assert_poll_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy) |=> rd_data[POLL_BIT] == ~$past(last_byte[POLL_BIT]));

  assert_low_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy) |=> rd_data[5:0] == $past(last_byte[5:0]));

  assert_flip_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (rd_data[TOGGLE_BIT] == $past(tog_cur)) && (tog_q != $past(tog_cur)));

  assert_array_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !busy) |=> rd_data == $past(array_data));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  assert_no_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_rd && !busy_start) |=> $stable(tog_q));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |-> !tog_cur);

  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_start && rd_stb) |=> !rd_data[TOGGLE_BIT] && tog_q);
endmodule

bind pstat_readback pstat_readback_chk #(
  .DATA_W     (DATA_W),
  .POLL_BIT   (POLL_BIT),
  .TOGGLE_BIT (TOGGLE_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_stb     (rd_stb),
  .busy       (busy),
  .last_byte  (last_byte),
  .array_data (array_data),
  .rd_data    (rd_data),
  .busy_start (busy_start),
  .status_rd  (status_rd),
  .tog_cur    (tog_cur),
  .tog_q      (tog_q)
);

// File: tb/sim_pstat_readback.sv
`timescale 1ns/1ps
module sim_pstat_readback;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_stb = 1'b0;
  logic       busy = 1'b0;
  logic [7:0] last_byte = 8'h00;
  logic [7:0] array_data = 8'h00;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  logic tog_m = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pstat_readback u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .busy       (busy),
    .last_byte  (last_byte),
    .array_data (array_data),
    .rd_data    (rd_data)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // Status word restated from the bit positions in the requirements.
  function automatic logic [7:0] model_word(input logic b, input logic t,
                                            input logic [7:0] lb, input logic [7:0] ar);
    if (!b) return ar;
    return {~lb[7], t, lb[5:0]};
  endfunction

  task automatic set_busy(input logic b);
    if (b && !busy) tog_m = 1'b0;
    busy = b;
  endtask

  // Drive one read strobe; the expected result goes to the scoreboard.
  task automatic do_read(input string tag);
    exp_q.push_back(model_word(busy, tog_m, last_byte, array_data));
    tag_q.push_back(tag);
    if (busy) tog_m = ~tog_m;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  // Monitor: a strobe at one edge gives a result by the following negedge (R10).
  initial begin
    forever begin
      @(posedge clk);
      if (rd_stb) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10: result with no expected item, got %02h expected none", rd_data);
        end else begin
          check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset value", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: array reads while idle
    array_data = 8'h3C; do_read("R5 array read a");
    array_data = 8'hA5; do_read("R5 array read b");

    // R2 R3 R4: status reads during a programming cycle
    last_byte = 8'h9B;
    set_busy(1'b1);
    @(negedge clk);
    array_data = 8'h11;
    do_read("R4 first busy read R2 R3");
    do_read("R4 second busy read");
    do_read("R4 third busy read");
    do_read("R4 fourth busy read");

    // R6: idle cycles do not move the output or the sequence
    @(negedge clk);
    held = rd_data;
    array_data = 8'hEE; last_byte = 8'h9A;
    repeat (3) @(negedge clk);
    check("R6 output held without strobe", rd_data, held);
    do_read("R6 sequence not advanced by idle cycles");

    // R9: completion, array now holds the programmed byte
    set_busy(1'b0);
    array_data = 8'h9A;
    @(negedge clk);
    do_read("R9 true bit 7 after completion");

    // R7 R8: busy rise and read in the same cycle, previous cycle ended on 1
    last_byte = 8'h7E;
    set_busy(1'b1);
    do_read("R8 R7 read in busy rise cycle");
    do_read("R8 next busy read");
    do_read("R4 third read of second cycle");

    // R5 after completion
    set_busy(1'b0);
    array_data = 8'h00; do_read("R5 array zero");
    array_data = 8'hFF; do_read("R5 array ones");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: pending results got %0d expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule